// File: doc/BRIEF.md
# Hard-Sectored FM Sector Formatter

This block turns one sector of a hard-sectored, single-density disk into a stream of raw FM bitcells. A rising edge on the hard-sector index input starts the sector. The block captures the low cylinder bits, the sector number and a flag that says whether the data source holds this sector. From then on it presents one bitcell at a time on `cellOut`. A downstream writer consumes a cell on every cycle in which `cellEn` is high, which nominally happens once per 2 µs cell period.

The sector is sent in this order:
- a leading run of zero bytes;
- an address sync word;
- two address bytes;
- a short run of zero bytes;
- a data sync word;
- 512 data bytes;
- a 16-bit checksum;
- zero padding up to a fixed sector length.

That fixed length follows from the revolution time, the cell period and the number of sectors: 648 bytes, or 10368 cells.

Data bytes arrive over a request/valid byte interface, and the block keeps one of them in hand ahead of use. When a sector is marked absent, the block makes no requests and sends a filler pattern in place of the data. A checksum unit follows the data bytes as they are loaded.

Top module: `fm_sector_formatter`

## Requirements
- R1: Every byte is sent as 16 cells, MSB first. Each data bit is a clock cell of 1 followed by a data cell equal to the bit, so a zero bit appears as 1,0.
- R2: A rising edge of `indexPulse` makes `sectorActive` high on the next cycle. The first 44 bytes of the sector (bytes 0..43) are zero.
- R3: Bytes 44..45 hold the address sync word 0x0001, sent high byte first. Bytes 53..54 hold the data sync word 0x0001, also high byte first.
- R4: Byte 46 is {5'b0, cylinderLow[2:0]}. Byte 47 is {2'b0, sectorNum[3:0], 2'b00}. Both values are taken at the index edge.
- R5: Bytes 48..52 are zero.
- R6: Bytes 55..566 are the data bytes, in the order the source delivers them. A byte is taken on a cycle with `byteReq` and `byteValid` both high. `byteReq`, once raised, stays high until it is served.
- R7: Bytes 567..568 are the checksum, high byte first. The register y starts at 0. For each data byte x, y becomes {y[7:0]^x, y[7:0]^y[15:8]}. The sent word is the value after one further step with x = 0.
- R8: Bytes 569..647 are zero, so the sector has exactly 10368 consumed cells. After that, `sectorActive` is low and `cellOut` is 0 until the next index edge. Both are also low after reset, with `byteReq` low as well.
- R9: When `sectorMissing` is high at the index edge, `byteReq` stays low for the whole sector. Data byte n (n = 0..511) is then 8'hC0 + (n mod 16), and the checksum covers these bytes.
- R10: A rising index edge during a sector restarts it from byte 0, including the data fetch count. An index held high causes no further restart.
- R11: `cellOut` changes only on a cycle with `cellEn` high or on an index edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cellEn | input | 1 | Consumes the current cell and advances to the next |
| indexPulse | input | 1 | Hard-sector index; its rising edge starts a sector |
| cylinderLow | input | 3 | Low bits of the cylinder number |
| sectorNum | input | 4 | Sector number |
| sectorMissing | input | 1 | Source has no data for this sector; use the filler |
| byteReq | output | 1 | Block wants the next data byte |
| byteValid | input | 1 | Source presents a byte on `byteData` |
| byteData | input | 8 | Data byte from the source |
| cellOut | output | 1 | Current FM cell |
| sectorActive | output | 1 | A sector is being sent |

## Verification
Two events can land in the same cycle. One is an index edge that arrives while a cell strobe is consuming a cell. The other is an index edge that arrives while a data byte is being fetched into the holding register. The restart scenario provokes both. Mid-sector, with strobes on every cycle and the prefetch already done, it raises the index again and resets the bench's source to byte 0. The result is judged by requiring the following sector to match byte for byte from byte 0, including the data order and the checksum, so a stale cell count or a kept prefetched byte would show up as shifted data.

// File: rtl/fmfmt_pkg.sv
package fmfmt_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_LEAD, PH_ASYNC, PH_ADDR, PH_MID, PH_DSYNC, PH_DATA, PH_CRC, PH_PAD
  } phase_t;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_ONE, SEL_ADDR0, SEL_ADDR1, SEL_DATA, SEL_CRC_HI, SEL_CRC_LO
  } byteSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     start;   // index edge: restart sector
    logic     load;    // byte boundary: load next byte
    byteSel_t sel;     // which byte to load
  } fmtStrobe_t;

  localparam int SYNC_BYTES = 2;
  localparam int ADDR_BYTES = 2;
  localparam int CRC_BYTES  = 2;

endpackage

// File: rtl/fmfmt_checksum.sv
module fmfmt_checksum (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        feed,
  input  logic [7:0]  inByte,
  output logic [15:0] outWord
);
  logic [15:0] y;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) y <= '0;
    else if (feed)       y <= {y[7:0] ^ inByte, y[7:0] ^ y[15:8]};
  end

  // closing step with a zero byte, folded into logic
  assign outWord = {y[7:0], y[7:0] ^ y[15:8]};
endmodule

// File: rtl/fmfmt_ctrl.sv
module fmfmt_ctrl
  import fmfmt_pkg::*;
#(
  parameter int LEAD_BYTES   = 44,
  parameter int MID_BYTES    = 5,
  parameter int DATA_BYTES   = 512,
  parameter int SECTOR_BYTES = 648,
  localparam int CNT_W       = $clog2(SECTOR_BYTES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cellEn,
  input  logic       indexPulse,
  output fmtStrobe_t strobe,
  output logic       active,
  output logic [3:0] cellIdx
);
  localparam int PAD_BYTES = SECTOR_BYTES -
    (LEAD_BYTES + 2*SYNC_BYTES + ADDR_BYTES + MID_BYTES + DATA_BYTES + CRC_BYTES);

  phase_t            phase, nPhase, succPhase;
  logic [CNT_W-1:0]  byteCnt, nCnt, phaseLen;
  logic              idxPrev, idxRise, byteEnd, lastInPhase;
  byteSel_t          nSel;

  assign idxRise = indexPulse & ~idxPrev;
  assign active  = (phase != PH_IDLE);
  assign byteEnd = active & cellEn & (cellIdx == 4'd15);

  always_comb begin
    case (phase)
      PH_LEAD:            phaseLen = CNT_W'(LEAD_BYTES);
      PH_ASYNC, PH_DSYNC: phaseLen = CNT_W'(SYNC_BYTES);
      PH_ADDR:            phaseLen = CNT_W'(ADDR_BYTES);
      PH_MID:             phaseLen = CNT_W'(MID_BYTES);
      PH_DATA:            phaseLen = CNT_W'(DATA_BYTES);
      PH_CRC:             phaseLen = CNT_W'(CRC_BYTES);
      PH_PAD:             phaseLen = CNT_W'(PAD_BYTES);
      default:            phaseLen = CNT_W'(1);
    endcase
  end

  always_comb begin
    case (phase)
      PH_LEAD:  succPhase = PH_ASYNC;
      PH_ASYNC: succPhase = PH_ADDR;
      PH_ADDR:  succPhase = PH_MID;
      PH_MID:   succPhase = PH_DSYNC;
      PH_DSYNC: succPhase = PH_DATA;
      PH_DATA:  succPhase = PH_CRC;
      PH_CRC:   succPhase = PH_PAD;
      default:  succPhase = PH_IDLE;
    endcase
  end

  assign lastInPhase = (byteCnt == phaseLen - CNT_W'(1));

  always_comb begin
    if (lastInPhase) begin
      nPhase = succPhase;
      nCnt   = '0;
    end else begin
      nPhase = phase;
      nCnt   = byteCnt + CNT_W'(1);
    end
  end

  // source of the byte that follows
  always_comb begin
    case (nPhase)
      PH_ASYNC, PH_DSYNC: nSel = (nCnt == CNT_W'(1)) ? SEL_ONE : SEL_ZERO;
      PH_ADDR:            nSel = (nCnt == '0) ? SEL_ADDR0 : SEL_ADDR1;
      PH_DATA:            nSel = SEL_DATA;
      PH_CRC:             nSel = (nCnt == '0) ? SEL_CRC_HI : SEL_CRC_LO;
      default:            nSel = SEL_ZERO;
    endcase
  end

  assign strobe.start = idxRise;
  assign strobe.load  = byteEnd & ~idxRise;
  assign strobe.sel   = nSel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idxPrev <= 1'b0;
      phase   <= PH_IDLE;
      byteCnt <= '0;
      cellIdx <= '0;
    end else begin
      idxPrev <= indexPulse;
      if (idxRise) begin
        phase   <= PH_LEAD;
        byteCnt <= '0;
        cellIdx <= '0;
      end else if (active && cellEn) begin
        cellIdx <= cellIdx + 4'd1;
        if (cellIdx == 4'd15) begin
          phase   <= nPhase;
          byteCnt <= nCnt;
        end
      end
    end
  end
endmodule

// File: rtl/fmfmt_datapath.sv
module fmfmt_datapath
  import fmfmt_pkg::*;
#(
  parameter int         DATA_BYTES = 512,
  parameter int         CYL_W      = 3,
  parameter int         SEC_W      = 4,
  parameter int         FILL_LEN   = 16,
  parameter logic [7:0] FILL_BASE  = 8'hC0,
  localparam int        FETCH_W    = $clog2(DATA_BYTES + 1),
  localparam int        FILL_W     = $clog2(FILL_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmtStrobe_t       strobe,
  input  logic             active,
  input  logic [3:0]       cellIdx,
  input  logic [CYL_W-1:0] cylinderLow,
  input  logic [SEC_W-1:0] sectorNum,
  input  logic             sectorMissing,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic [15:0]      crcWord,
  output logic             byteReq,
  output logic             cellOut,
  output logic             crcClear,
  output logic             crcFeed,
  output logic [7:0]       crcByte
);
  localparam logic [FETCH_W-1:0] FETCH_MAX = FETCH_W'(DATA_BYTES);

  logic [7:0]         curByte, holdByte, nextByte, dataByte, fillByte;
  logic [CYL_W-1:0]   cylQ;
  logic [SEC_W-1:0]   secQ;
  logic               missQ, holdFull, accept, bitPick;
  logic [FETCH_W-1:0] fetchCnt;
  logic [FILL_W-1:0]  fillIdx;

  assign byteReq  = active & ~missQ & ~holdFull & (fetchCnt < FETCH_MAX);
  assign accept   = byteReq & byteValid;
  assign fillByte = FILL_BASE + 8'(fillIdx);
  assign dataByte = (missQ || !holdFull) ? fillByte : holdByte;

  always_comb begin
    case (strobe.sel)
      SEL_ONE:    nextByte = 8'h01;
      SEL_ADDR0:  nextByte = 8'(cylQ);
      SEL_ADDR1:  nextByte = 8'({secQ, 2'b00});
      SEL_DATA:   nextByte = dataByte;
      SEL_CRC_HI: nextByte = crcWord[15:8];
      SEL_CRC_LO: nextByte = crcWord[7:0];
      default:    nextByte = 8'h00;
    endcase
  end

  assign crcClear = strobe.start;
  assign crcFeed  = strobe.load & (strobe.sel == SEL_DATA);
  assign crcByte  = dataByte;

  assign bitPick = curByte[3'd7 - cellIdx[3:1]];
  assign cellOut = active & (~cellIdx[0] | bitPick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curByte  <= '0;
      holdByte <= '0;
      holdFull <= 1'b0;
      cylQ     <= '0;
      secQ     <= '0;
      missQ    <= 1'b0;
      fetchCnt <= '0;
      fillIdx  <= '0;
    end else if (strobe.start) begin
      curByte  <= '0;
      holdFull <= 1'b0;
      cylQ     <= cylinderLow;
      secQ     <= sectorNum;
      missQ    <= sectorMissing;
      fetchCnt <= '0;
      fillIdx  <= '0;
    end else begin
      if (accept) begin
        holdByte <= byteData;
        holdFull <= 1'b1;
        fetchCnt <= fetchCnt + FETCH_W'(1);
      end
      if (strobe.load) begin
        curByte <= nextByte;
        if (strobe.sel == SEL_DATA) begin
          fillIdx <= fillIdx + FILL_W'(1);
          if (!missQ && holdFull) holdFull <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fm_sector_formatter.sv
module fm_sector_formatter
  import fmfmt_pkg::*;
#(
  parameter int REV_US     = 166000,
  parameter int CELL_US    = 2,
  parameter int SECTORS    = 8,
  parameter int LEAD_BYTES = 44,
  parameter int MID_BYTES  = 5,
  parameter int DATA_BYTES = 512,
  parameter int CYL_W      = 3,
  parameter int SEC_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cellEn,
  input  logic             indexPulse,
  input  logic [CYL_W-1:0] cylinderLow,
  input  logic [SEC_W-1:0] sectorNum,
  input  logic             sectorMissing,
  output logic             byteReq,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  output logic             cellOut,
  output logic             sectorActive
);
  localparam int SECTOR_BYTES = REV_US / CELL_US / SECTORS / 16;

  fmtStrobe_t  strobe;
  logic [3:0]  cellIdx;
  logic [15:0] crcWord;
  logic [7:0]  crcByte;
  logic        crcClear, crcFeed;

  fmfmt_ctrl #(
    .LEAD_BYTES(LEAD_BYTES), .MID_BYTES(MID_BYTES),
    .DATA_BYTES(DATA_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cellEn(cellEn), .indexPulse(indexPulse),
    .strobe(strobe), .active(sectorActive), .cellIdx(cellIdx)
  );

  fmfmt_datapath #(
    .DATA_BYTES(DATA_BYTES), .CYL_W(CYL_W), .SEC_W(SEC_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .active(sectorActive),
    .cellIdx(cellIdx), .cylinderLow(cylinderLow), .sectorNum(sectorNum),
    .sectorMissing(sectorMissing), .byteValid(byteValid), .byteData(byteData),
    .crcWord(crcWord), .byteReq(byteReq), .cellOut(cellOut),
    .crcClear(crcClear), .crcFeed(crcFeed), .crcByte(crcByte)
  );

  fmfmt_checksum u_crc (
    .clk(clk), .rst_n(rst_n), .clear(crcClear), .feed(crcFeed),
    .inByte(crcByte), .outWord(crcWord)
  );
endmodule

// File: rtl/fmfmt_checker.sv
module fmfmt_checker (
  input logic clk,
  input logic rst_n,
  input logic cellEn,
  input logic indexPulse,
  input logic sectorMissing,
  input logic byteReq,
  input logic byteValid,
  input logic cellOut,
  input logic sectorActive
);
  logic idxPrevC, idxRiseC, missC, cellPar;

  assign idxRiseC = indexPulse & ~idxPrevC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idxPrevC <= 1'b0;
      missC    <= 1'b0;
      cellPar  <= 1'b0;
    end else begin
      idxPrevC <= indexPulse;
      if (idxRiseC) begin
        missC   <= sectorMissing;
        cellPar <= 1'b0;
      end else if (sectorActive && cellEn) begin
        cellPar <= ~cellPar;
      end
    end
  end

  assert_clock_cell_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sectorActive && !cellPar) |-> cellOut);

  assert_start_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idxRiseC |=> sectorActive);

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byteReq && !byteValid && !idxRiseC) |=> byteReq);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sectorActive |-> !cellOut);

  assert_no_req_missing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sectorActive && missC && !idxRiseC) |-> !byteReq);

  assert_cell_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sectorActive && !cellEn && !idxRiseC) |=> $stable(cellOut));
endmodule

bind fm_sector_formatter fmfmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cellEn(cellEn), .indexPulse(indexPulse),
  .sectorMissing(sectorMissing), .byteReq(byteReq), .byteValid(byteValid),
  .cellOut(cellOut), .sectorActive(sectorActive)
);

// File: tb/fm_sector_formatter_test.sv
module fm_sector_formatter_test;
  localparam int SEC_BYTES = 648;
  localparam int SEC_CELLS = SEC_BYTES * 16;

  logic clk = 0, rst_n = 0, cellEn = 0, indexPulse = 0, sectorMissing = 0;
  logic byteValid = 0;
  logic [7:0] byteData = 0;
  logic [2:0] cylinderLow = 0;
  logic [3:0] sectorNum = 0;
  logic byteReq, cellOut, sectorActive;

  int total = 0, bad = 0;
  logic [7:0] gotB [0:SEC_BYTES-1];
  logic [7:0] expB [0:SEC_BYTES-1];
  int cellCount, clkBad, reqSeen, holdBad;

  always #4 clk = ~clk;

  fm_sector_formatter uut (
    .clk(clk), .rst_n(rst_n), .cellEn(cellEn), .indexPulse(indexPulse),
    .cylinderLow(cylinderLow), .sectorNum(sectorNum), .sectorMissing(sectorMissing),
    .byteReq(byteReq), .byteValid(byteValid), .byteData(byteData),
    .cellOut(cellOut), .sectorActive(sectorActive)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] srcByte(input logic [7:0] seed, input int n);
    return 8'((int'(seed) + n * 29 + (n >> 4)) & 255);
  endfunction

  // expected sector image built from the requirements
  task automatic build_expect(input logic [2:0] cyl, input logic [3:0] sec,
                              input bit miss, input logic [7:0] seed);
    logic [15:0] y = 0;
    logic [7:0]  d;
    for (int i = 0; i < SEC_BYTES; i++) expB[i] = 8'h00;
    expB[45] = 8'h01;                 // R3 address sync low byte
    expB[54] = 8'h01;                 // R3 data sync low byte
    expB[46] = {5'b0, cyl};           // R4
    expB[47] = {2'b0, sec, 2'b00};    // R4
    for (int n = 0; n < 512; n++) begin
      d = miss ? 8'(8'hC0 + (n % 16)) : srcByte(seed, n);
      expB[55 + n] = d;
      y = {y[7:0] ^ d, y[7:0] ^ y[15:8]};
    end
    y = {y[7:0], y[7:0] ^ y[15:8]};   // R7 closing zero step
    expB[567] = y[15:8];
    expB[568] = y[7:0];
  endtask

  // runs a sector from an index edge; optional restart after abortAt cells
  task automatic run_sector(input logic [2:0] cyl, input logic [3:0] sec,
                            input bit miss, input logic [7:0] seed,
                            input int div, input int abortAt);
    int k = 0, srcIdx = 0, ph = 0, hiCnt = 4;
    bit started = 0, restarted = 0, prevEn = 1, skipHold = 0, en;
    logic prevCell = 0;
    for (int i = 0; i < SEC_BYTES; i++) gotB[i] = 8'h55;
    clkBad = 0; reqSeen = 0; holdBad = 0;
    @(negedge clk);
    cylinderLow = cyl; sectorNum = sec; sectorMissing = miss;
    byteValid = 0; indexPulse = 1; cellEn = 0;
    for (int cyc = 0; cyc < 40000 * div; cyc++) begin
      @(negedge clk);
      if (hiCnt > 0) begin
        hiCnt--;
        if (hiCnt == 0) indexPulse = 0;
      end
      if (byteReq) reqSeen++;
      if (byteReq && !byteValid) begin
        byteValid = 1; byteData = srcByte(seed, srcIdx); srcIdx++;
      end else byteValid = 0;
      if (started && sectorActive && !prevEn && !skipHold && cellOut !== prevCell)
        holdBad++;
      skipHold = 0;
      if (sectorActive) started = 1;
      if (started && !sectorActive) break;
      en = ((ph % div) == 0);
      ph++;
      cellEn = en;
      if (sectorActive && en) begin
        if (k % 2 == 0) begin
          if (cellOut !== 1'b1) clkBad++;
        end else if (k / 16 < SEC_BYTES) begin
          gotB[k / 16][7 - ((k % 16) / 2)] = cellOut;
        end
        k++;
      end
      prevCell = cellOut; prevEn = en;
      if (abortAt > 0 && !restarted && k == abortAt) begin
        restarted = 1; indexPulse = 1; hiCnt = 4;
        k = 0; srcIdx = 0; byteValid = 0; skipHold = 1; reqSeen = 0;
      end
    end
    cellEn = 0; byteValid = 0;
    cellCount = k;
  endtask

  task automatic compare_region(input int lo, input int hi, input string req,
                                input string what);
    int mism = 0, firstAt = -1;
    for (int i = lo; i <= hi; i++)
      if (gotB[i] !== expB[i]) begin
        mism++;
        if (firstAt < 0) firstAt = i;
      end
    if (firstAt >= 0)
      check(0, req, $sformatf("%s byte %0d", what, firstAt),
            int'(gotB[firstAt]), int'(expB[firstAt]));
    else check(1, req, what, 0, 0);
  endtask

  task automatic verify_sector(input string tag, input bit miss);
    check(cellCount == SEC_CELLS, "R8", {tag, " cell count"}, cellCount, SEC_CELLS);
    check(clkBad == 0, "R1", {tag, " clock cells"}, clkBad, 0);
    compare_region(0, 43, "R2", {tag, " lead gap"});
    compare_region(44, 45, "R3", {tag, " address sync"});
    compare_region(53, 54, "R3", {tag, " data sync"});
    compare_region(46, 47, "R4", {tag, " address bytes"});
    compare_region(48, 52, "R5", {tag, " mid gap"});
    if (miss) begin
      compare_region(55, 566, "R9", {tag, " filler data"});
      check(reqSeen == 0, "R9", {tag, " no requests"}, reqSeen, 0);
    end else begin
      compare_region(55, 566, "R6", {tag, " data bytes"});
    end
    compare_region(567, 568, "R7", {tag, " checksum"});
    compare_region(569, SEC_BYTES - 1, "R8", {tag, " padding"});
    check(holdBad == 0, "R11", {tag, " cell held between strobes"}, holdBad, 0);
    repeat (5) @(negedge clk);
    check(sectorActive === 1'b0 && cellOut === 1'b0, "R8", {tag, " idle after sector"},
          int'({sectorActive, cellOut}), 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(sectorActive === 1'b0, "R8", "reset active", int'(sectorActive), 0);
    check(cellOut === 1'b0, "R8", "reset cellOut", int'(cellOut), 0);
    check(byteReq === 1'b0, "R8", "reset byteReq", int'(byteReq), 0);
  endtask

  task automatic test_full_rate();
    build_expect(3'd5, 4'd3, 0, 8'h17);
    run_sector(3'd5, 4'd3, 0, 8'h17, 1, 0);
    verify_sector("full rate", 0);
  endtask

  task automatic test_slow_strobe();
    build_expect(3'd6, 4'd15, 0, 8'hA4);
    run_sector(3'd6, 4'd15, 0, 8'hA4, 3, 0);
    verify_sector("strobe every third cycle", 0);
  endtask

  task automatic test_missing();
    build_expect(3'd2, 4'd7, 1, 8'h00);
    run_sector(3'd2, 4'd7, 1, 8'h00, 1, 0);
    verify_sector("missing sector", 1);
  endtask

  task automatic test_restart();
    build_expect(3'd1, 4'd9, 0, 8'h3C);
    run_sector(3'd1, 4'd9, 0, 8'h3C, 1, 3001);
    check(cellCount == SEC_CELLS, "R10", "restart cell count", cellCount, SEC_CELLS);
    compare_region(0, SEC_BYTES - 1, "R10", "restarted sector image");
    verify_sector("restart", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_full_rate();
    test_slow_strobe();
    test_missing();
    test_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule